// File: doc/BRIEF.md
# Week Alarm Wake Timer

A timer for the always-powered battery domain. It counts a 32.768 kHz tick, which the surrounding logic brings in as a one-cycle enable on the system clock. The tick is divided down to a once-per-second strobe and to a sub-second strobe whose rate software selects. The seconds advance an up-counting week counter, which is compared against a programmable compare value. The sub-second strobes step a down-counting sub-week counter towards zero.

The block emits single-cycle pulses for four events: the week alarm, the sub-week alarm, the one-second tick and the sub-second tick. It also drives a sticky power-up request, which either alarm can raise. The request holds until software drops its enable. It can be suppressed when an optional gate is on and the synchronized system-power-present input is low, so that a timeout cannot wake a machine running on battery alone. Masking of the event pulses is left to a downstream interrupt collector.

Software reaches the fields through a one-cycle write port and a registered read port that share one address. The read data follows the address one clock later.

Top module: `wkalarm_timer`

## Requirements
- R1: Address 0 holds the control fields: bit 0 run enable, bit 1 power-up enable, bit 2 power-present gate enable, bits 7:4 rate select. Address 1 holds the week compare value. A write lands at the clock edge. `rdata_o` shows the register at the address presented in the previous cycle, zero-extended; bit 3 and the bits above 7 read 0 at address 0.
- R2: `week_evt_o` pulses for exactly one cycle, one cycle after the week counter first becomes greater than or equal to the compare value while the block is enabled.
- R3: The week counter (address 2) increments once per one-second strobe and wraps at its width. A write to it wins over an increment in the same cycle.
- R4: The sub-week counter (address 3) decrements once per sub-second strobe while it is nonzero and rests at 0. A write to it wins over a decrement in the same cycle.
- R5: `subwk_evt_o` pulses for one cycle only when a sub-second strobe takes the sub-week counter from 1 to 0. A write that loads 0, or a counter resting at 0, gives no pulse.
- R6: `sec_evt_o` pulses once every 2^TPS_LOG2 ticks, one cycle after the tick that completes the second.
- R7: With rate select v, v = 0 gives no sub-second pulse. v = 1..15 gives one pulse every 2^min(v-1, TPS_LOG2+1) ticks, aligned to the one-second phase.
- R8: When a week-alarm condition or a sub-week pulse occurs while the power-up request is allowed, `pwrup_o` is set. It then stays high as long as the power-up enable is 1.
- R9: While the power-up enable is 0, `pwrup_o` is driven low (one cycle after the enable is seen low) and cannot be set.
- R10: While the gate enable is 1 and the two-flop-synchronized `syspwr_i` is 0, `pwrup_o` cannot be set.
- R11: While the run enable is 0, the prescaler is held at zero, the counters do not step and no event pulse is produced.
- R12: After reset all registers and counters are 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle 32.768 kHz tick enable |
| syspwr_i | input | 1 | System power present, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| week_evt_o | output | 1 | Week alarm pulse |
| subwk_evt_o | output | 1 | Sub-week alarm pulse |
| sec_evt_o | output | 1 | One-second pulse |
| subsec_evt_o | output | 1 | Sub-second pulse |
| pwrup_o | output | 1 | Sticky power-up request |

## Verification
Two things can land on the same clock edge: a software write to a counter and a tick that would step that same counter. With ticks on every cycle, the bench writes the week and sub-week counters back to back. In one of those writes, the sub-week counter sits at 1 at the instant a sub-second strobe would take it to 0. The cycle-level reference model applies the write-wins rule and expects no sub-week pulse in that case. The outputs and the read-back counter values are then compared on every clock.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMP   = 2'd1;
  localparam logic [ADDR_W-1:0] A_WEEK  = 2'd2;
  localparam logic [ADDR_W-1:0] A_SUBWK = 2'd3;

  typedef struct packed {
    logic [3:0] rate;
    logic       gate_en;
    logic       pu_en;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/wkt_prescaler.sv
module wkt_prescaler #(
  parameter int TPS_LOG2 = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic [3:0] rate,
  output logic       sec_stb,
  output logic       sub_stb
);
  localparam int PS_W = TPS_LOG2 + 1;
  localparam logic [PS_W:0] ONE = 1;

  logic [PS_W-1:0] ps, ps_nx;
  logic [PS_W:0]   mask;
  int              sh;

  always_comb begin
    ps_nx = ps + 1'b1;
    sh = int'(rate) - 1;
    if (sh > PS_W) sh = PS_W;
    if (sh < 0) sh = 0;
    mask = (ONE << sh) - ONE;
    sec_stb = en && tick && (ps_nx[TPS_LOG2-1:0] == '0);
    sub_stb = en && tick && (rate != 4'd0) && (({1'b0, ps_nx} & mask) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) ps <= '0;
    else if (tick)  ps <= ps_nx;
  end
endmodule

// File: rtl/wkt_counters.sv
module wkt_counters import wkt_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int WEEK_W  = 32,
  parameter int SUBWK_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sec_stb,
  input  logic              sub_stb,
  output ctrl_t             ctrl_o,
  output logic              week_lvl_o,
  output logic              subw_stb_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [WEEK_W-1:0]  cmp, wcnt;
  logic [SUBWK_W-1:0] scnt;
  logic [DATA_W-1:0]  rd_c;
  logic               wr_ctrl, wr_cmp, wr_week, wr_sub;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cmp  = wr_en && (addr == A_CMP);
  assign wr_week = wr_en && (addr == A_WEEK);
  assign wr_sub  = wr_en && (addr == A_SUBWK);

  assign week_lvl_o = ctrl_o.en && (wcnt >= cmp);
  assign subw_stb_o = sub_stb && !wr_sub && (scnt == SUBWK_W'(1));

  always_comb begin
    rd_c = '0;
    case (addr)
      A_CTRL:  rd_c[7:0] = {ctrl_o.rate, 1'b0, ctrl_o.gate_en, ctrl_o.pu_en, ctrl_o.en};
      A_CMP:   rd_c[WEEK_W-1:0] = cmp;
      A_WEEK:  rd_c[WEEK_W-1:0] = wcnt;
      default: rd_c[SUBWK_W-1:0] = scnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o  <= '0;
      cmp     <= '0;
      wcnt    <= '0;
      scnt    <= '0;
      rdata_o <= '0;
    end else begin
      rdata_o <= rd_c;
      if (wr_ctrl) ctrl_o <= '{rate: wdata[7:4], gate_en: wdata[2], pu_en: wdata[1], en: wdata[0]};
      if (wr_cmp) cmp <= wdata[WEEK_W-1:0];
      if (wr_week)      wcnt <= wdata[WEEK_W-1:0];
      else if (sec_stb) wcnt <= wcnt + 1'b1;
      if (wr_sub)                      scnt <= wdata[SUBWK_W-1:0];
      else if (sub_stb && scnt != '0) scnt <= scnt - 1'b1;
    end
  end
endmodule

// File: rtl/wkt_wake.sv
module wkt_wake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic syspwr_i,
  input  logic pu_en,
  input  logic gate_en,
  input  logic week_lvl,
  input  logic subw_stb,
  output logic pwrup_o
);
  logic [SYNC_STAGES-1:0] sync;
  logic                   allowed;

  assign allowed = pu_en && !(gate_en && !sync[SYNC_STAGES-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync    <= '0;
      pwrup_o <= 1'b0;
    end else begin
      sync <= {sync[SYNC_STAGES-2:0], syspwr_i};
      if (!pu_en) pwrup_o <= 1'b0;
      else        pwrup_o <= pwrup_o || (allowed && (week_lvl || subw_stb));
    end
  end
endmodule

// File: rtl/wkalarm_timer.sv
module wkalarm_timer import wkt_pkg::*; #(
  parameter int TPS_LOG2 = 15,
  parameter int DATA_W   = 32,
  parameter int WEEK_W   = 32,
  parameter int SUBWK_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              syspwr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              week_evt_o,
  output logic              subwk_evt_o,
  output logic              sec_evt_o,
  output logic              subsec_evt_o,
  output logic              pwrup_o
);
  ctrl_t ctrl;
  logic  sec_stb, sub_stb, week_lvl, subw_stb, lvl_q;
  logic  blk_en, pu_en;

  assign blk_en = ctrl.en;
  assign pu_en  = ctrl.pu_en;

  wkt_prescaler #(.TPS_LOG2(TPS_LOG2)) u_pre (
    .clk(clk), .rst(rst), .en(ctrl.en), .tick(tick_i), .rate(ctrl.rate),
    .sec_stb(sec_stb), .sub_stb(sub_stb));

  wkt_counters #(.DATA_W(DATA_W), .WEEK_W(WEEK_W), .SUBWK_W(SUBWK_W)) u_cnt (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
    .sec_stb(sec_stb), .sub_stb(sub_stb), .ctrl_o(ctrl),
    .week_lvl_o(week_lvl), .subw_stb_o(subw_stb), .rdata_o(rdata_o));

  wkt_wake #(.SYNC_STAGES(2)) u_wake (
    .clk(clk), .rst(rst), .syspwr_i(syspwr_i), .pu_en(ctrl.pu_en),
    .gate_en(ctrl.gate_en), .week_lvl(week_lvl), .subw_stb(subw_stb),
    .pwrup_o(pwrup_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q        <= 1'b0;
      week_evt_o   <= 1'b0;
      subwk_evt_o  <= 1'b0;
      sec_evt_o    <= 1'b0;
      subsec_evt_o <= 1'b0;
    end else begin
      lvl_q        <= week_lvl;
      week_evt_o   <= week_lvl && !lvl_q;
      subwk_evt_o  <= subw_stb;
      sec_evt_o    <= sec_stb;
      subsec_evt_o <= sub_stb;
    end
  end
endmodule

// File: rtl/wkalarm_timer_sva.sv
module wkalarm_timer_sva (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic blk_en,
  input logic pu_en,
  input logic week_evt,
  input logic subwk_evt,
  input logic sec_evt,
  input logic subsec_evt,
  input logic pwrup
);
  a_r2_week_single: assert property (@(posedge clk) disable iff (rst)
    week_evt |=> !week_evt);
  a_r6_sec_after_tick: assert property (@(posedge clk) disable iff (rst)
    sec_evt |-> $past(tick_i && blk_en));
  a_r5_subwk_after_tick: assert property (@(posedge clk) disable iff (rst)
    subwk_evt |-> $past(tick_i && blk_en));
  a_r8_pwrup_sticky: assert property (@(posedge clk) disable iff (rst)
    (pwrup && pu_en) |=> pwrup);
  a_r9_pwrup_release: assert property (@(posedge clk) disable iff (rst)
    !pu_en |=> !pwrup);
  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !blk_en |=> !(week_evt || subwk_evt || sec_evt || subsec_evt));
endmodule

bind wkalarm_timer wkalarm_timer_sva u_sva (
  .clk(clk), .rst(rst), .tick_i(tick_i), .blk_en(blk_en), .pu_en(pu_en),
  .week_evt(week_evt_o), .subwk_evt(subwk_evt_o), .sec_evt(sec_evt_o),
  .subsec_evt(subsec_evt_o), .pwrup(pwrup_o));

// File: tb/wkalarm_timer_test.sv
module wkalarm_timer_test;
  localparam int L = 4;
  logic clk = 0, rst = 1, tick = 0, syspwr = 0, wr_en = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic week_o, subw_o, sec_o, sub_o, pu_o;
  int checks = 0, errors = 0, cnt = 0, tmode = 0;
  bit started = 0, done = 0;

  always #5 clk = ~clk;

  wkalarm_timer #(.TPS_LOG2(L)) uut (
    .clk(clk), .rst(rst), .tick_i(tick), .syspwr_i(syspwr), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .week_evt_o(week_o),
    .subwk_evt_o(subw_o), .sec_evt_o(sec_o), .subsec_evt_o(sub_o), .pwrup_o(pu_o));

  // reference model state
  bit m_en, m_pu_en, m_gate, m_lvlq, m_s1, m_s2;
  bit m_week, m_subw, m_sec, m_sub, m_pu, m_rst_seen;
  int m_rate, m_ps, m_scnt;
  bit [31:0] m_cmp, m_wcnt, m_rd;
  string m_rd_tag;

  function automatic bit [31:0] rd_of(logic [1:0] a);
    case (a)
      2'd0: return {24'b0, 4'(m_rate), 1'b0, m_gate, m_pu_en, m_en};
      2'd1: return m_cmp;
      2'd2: return m_wcnt;
      default: return 32'(m_scnt);
    endcase
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      {m_en, m_pu_en, m_gate, m_lvlq, m_s1, m_s2} = '0;
      {m_week, m_subw, m_sec, m_sub, m_pu} = '0;
      m_rate = 0; m_ps = 0; m_scnt = 0; m_cmp = 0; m_wcnt = 0; m_rd = 0;
      m_rd_tag = "R12"; m_rst_seen = 1;
    end else begin
      bit sec, sub, lvl, subw, allowed, pu_n, w0, w1, w2, w3;
      int ps_n, sh;
      sec = 0; sub = 0; ps_n = m_ps;
      if (!m_en) ps_n = 0;
      else if (tick) begin
        ps_n = (m_ps + 1) % (2 ** (L + 1));
        sec = (ps_n % (2 ** L)) == 0;
        if (m_rate != 0) begin
          sh = (m_rate - 1 > L + 1) ? L + 1 : m_rate - 1;
          sub = (ps_n % (2 ** sh)) == 0;
        end
      end
      w0 = wr_en && addr == 0; w1 = wr_en && addr == 1;
      w2 = wr_en && addr == 2; w3 = wr_en && addr == 3;
      lvl = m_en && (m_wcnt >= m_cmp);
      subw = sub && !w3 && (m_scnt == 1);
      allowed = m_pu_en && !(m_gate && !m_s2);
      pu_n = !m_pu_en ? 0 : (m_pu || (allowed && (lvl || subw)));
      m_rd = rd_of(addr);
      m_rd_tag = (addr == 2) ? "R3" : (addr == 3) ? "R4" : "R1";
      m_week = lvl && !m_lvlq; m_lvlq = lvl;
      m_sec = sec; m_sub = sub; m_subw = subw; m_pu = pu_n; m_ps = ps_n;
      m_s2 = m_s1; m_s1 = syspwr;
      if (w2) m_wcnt = wdata; else if (sec) m_wcnt = m_wcnt + 1;
      if (w3) m_scnt = int'(wdata[8:0]); else if (sub && m_scnt != 0) m_scnt = m_scnt - 1;
      if (w1) m_cmp = wdata;
      if (w0) begin
        m_en = wdata[0]; m_pu_en = wdata[1]; m_gate = wdata[2]; m_rate = int'(wdata[7:4]);
      end
      m_rst_seen = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    string t;
    t = m_rst_seen ? "R12" : "";
    chk(t != "" ? t : (m_en ? "R2" : "R11"), 32'(week_o), 32'(m_week));
    chk(t != "" ? t : (m_en ? "R5" : "R11"), 32'(subw_o), 32'(m_subw));
    chk(t != "" ? t : (m_en ? "R6" : "R11"), 32'(sec_o), 32'(m_sec));
    chk(t != "" ? t : (m_en ? "R7" : "R11"), 32'(sub_o), 32'(m_sub));
    chk(t != "" ? t : "R8/R9/R10", 32'(pu_o), 32'(m_pu));
    chk(t != "" ? t : m_rd_tag, rdata, m_rd);
  end

  task automatic drive_tick();
    tick = (tmode == 0) ? 1'b1 : (cnt % 3 == 0);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk) begin
      wr_en = 0; addr = 2'(cnt % 4); drive_tick(); cnt++;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; drive_tick(); cnt++;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    step(6);                                   // R12 reset state
    wr(1, 3); wr(2, 0); wr(0, 32'h33);         // R2 R3 R6 R7: week alarm after 3 s
    step(80);
    wr(0, 32'h31); step(6);                    // R9 release
    wr(0, 32'h33); step(6);                    // R8 level re-raises
    wr(1, 1000); wr(0, 32'h21); step(3);
    wr(3, 4); wr(0, 32'h23); step(40);         // R4 R5 sub-week countdown
    wr(0, 32'h21); syspwr = 0; wr(3, 3); wr(0, 32'h27);
    step(40);                                  // R10 gated
    syspwr = 1; step(4); wr(3, 2); step(40);   // R10 released
    wr(0, 32'h11); wr(3, 1); wr(3, 5); wr(2, 7);
    wr(3, 0); step(20);                        // R3 R4 R5 write collisions
    tmode = 1;
    wr(0, 32'hF1); wr(3, 3); step(300);        // R7 clamped rate
    wr(0, 32'h01); step(60);                   // R7 rate zero
    wr(0, 32'h00); wr(2, 5); step(40);         // R11 disabled
    wr(0, 32'h53); wr(1, 2); wr(2, 1); step(150);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule